// File: doc/BRIEF.md
# Byte-Synchronous Character Receiver with SYNC Stripping

This block receives a byte-oriented synchronous serial stream. One serial bit arrives on each rising edge of the receive clock. While idle it hunts for character alignment: on every bit it compares the most recent bits with a programmed SYNC pattern. Once it finds the pattern it frames the stream into characters of 5 to 8 bits.

After lock, SYNC characters are either dropped or kept, depending on a strip control. Data characters are placed in a single holding register for the host, which flags them with a data-available output. A 16-bit block check can be accumulated over the delivered characters. The host compares that check value against the received check characters.

The host pulses a read input to acknowledge each character. Dropping the enable input returns the receiver to the hunt and clears everything it has gathered.

Top module: `rxs_receiver`

## Requirements
- R1: Serial bits are least significant first: the first bit received of a character is bit 0. While hunting, on every bit, the last L received bits are compared with the low L bits of `sync_char`. The comparison is made only once at least L bits have arrived since enable.
- R2: The character width L is set by `len_code`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Delivered characters are right-aligned in `rx_data`, and the unused upper bits read 0.
- R3: After lock, characters are framed every L bits, counted from the bit after the locking SYNC. SYNC comparison is then made only at those character boundaries.
- R4: With `strip_sync`=1, one SYNC locks the receiver. From then on, characters equal to the SYNC are discarded and do not enter the block check. Every other character is delivered, starting with the first non-SYNC one.
- R5: With `strip_sync`=0, a second SYNC must immediately follow the first, and every character after it is delivered, including SYNC values. If the character after the first SYNC is not a SYNC, the receiver goes back to hunting and its block check is cleared.
- R6: `sync_pulse` is high for exactly one cycle after each clock edge that samples the last bit of a SYNC. This covers the SYNC found in the hunt and any SYNC found at a framed boundary.
- R7: `rx_data` and `data_avail` update after the edge that samples the last bit of a delivered character. `host_rd` clears `data_avail` at the next edge, unless a new character is delivered on that same edge, in which case the new character wins.
- R8: `rx_active` rises together with the first delivered character and falls only when `rx_en` is low.
- R9: When `rx_en` is low, the receiver returns to the hunt. It clears its bit history, `data_avail`, `rx_active`, `sync_pulse`, `rx_data` and the block check.
- R10: `chk_mode` selects the block check. 1 selects CRC-16 (poly 0x8005) and 2 selects CRC-CCITT (poly 0x1021). 0 and 3 select none, and the check then stays 0. The register is preset to zero and shifts left, with feedback equal to the input bit XOR bit 15. The L bits of each delivered character are fed in bit 0 first. `chk_value` is the true remainder.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; data sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low forces the hunt and clears state |
| rx_din | input | 1 | Serial data, mark = 1 |
| sync_char | input | 8 | Programmed SYNC pattern (low L bits used) |
| strip_sync | input | 1 | 1 discards SYNC characters after lock |
| len_code | input | 2 | Character width code (L = code + 5) |
| chk_mode | input | 2 | Block check select |
| host_rd | input | 1 | Host acknowledge of the held character |
| sync_pulse | output | 1 | One-cycle SYNC detected pulse |
| rx_active | output | 1 | Message in progress |
| data_avail | output | 1 | Character waiting in `rx_data` |
| rx_data | output | 8 | Received character, right-aligned |
| chk_value | output | 16 | Accumulated block check remainder |

## Verification
A wrong bit counter or a lost lock shows up at the next character boundary. The next delivered character appears on the wrong cycle or with shifted bits, and the following SYNC gives no `sync_pulse` or a misplaced one, so the error is visible within L cycles.

A wrong block-check step changes `chk_value` on the very cycle the character is delivered. A state machine that leaves the hunt on the wrong rule shows up as data delivered too early, or as SYNC values delivered when they should be dropped. The bench compares every output against a behavioural model on every cycle, so each of these errors is reported in the cycle it first appears.

// File: rtl/rxs_pkg.sv
// Shared types and constants for the byte-synchronous receiver.
// Assumes one serial bit per receive clock.
package rxs_pkg;
    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_ONE_SYNC = 2'd1,
        ST_DATA     = 2'd2
    } rx_state_e;

    localparam logic [1:0] CHK_NONE  = 2'd0;
    localparam logic [1:0] CHK_CRC16 = 2'd1;
    localparam logic [1:0] CHK_CCITT = 2'd2;
endpackage

// File: rtl/rxs_deser.sv
// Serial deserialiser: keeps the recent bit history and presents the
// window of the last LEN bits (including the bit being sampled now),
// right-aligned. Also tracks the fill level and the in-character bit
// position. Assumes LEN stays constant while enabled.
module rxs_deser #(
    parameter int MAXW = 8,
    localparam int CW = $clog2(MAXW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            align,
    input  logic            rx_din,
    input  logic [CW-1:0]   len,
    output logic [MAXW-1:0] win,
    output logic            enough,
    output logic            boundary
);
    logic [MAXW-1:0] sr;
    logic [MAXW-1:0] sr_nxt;
    logic [CW-1:0]   fill;
    logic [CW-1:0]   bitcnt;

    // Form the window with the bit currently being sampled.
    always_comb begin
        sr_nxt   = {rx_din, sr[MAXW-1:1]};
        win      = sr_nxt >> (MAXW - int'(len));
        enough   = (int'(fill) + 1) >= int'(len);
        boundary = int'(bitcnt) == (int'(len) - 1);
    end

    // Shift history, saturating fill count and modulo-LEN bit position.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sr     <= '0;
            fill   <= '0;
            bitcnt <= '0;
        end else begin
            sr <= sr_nxt;
            if (int'(fill) != MAXW)
                fill <= fill + 1'b1;
            if (align || boundary)
                bitcnt <= '0;
            else
                bitcnt <= bitcnt + 1'b1;
        end
    end

    assert_bitcnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n || clr)
        int'(bitcnt) < int'(len))
        else $error("bit position beyond character width");
endmodule

// File: rtl/rxs_bcc.sv
// Block check accumulator: a shift-left 16-bit CRC, preset to zero.
// Each update folds in LEN character bits, bit 0 first.
// Mode picks the polynomial; other modes hold the value at zero.
module rxs_bcc #(
    parameter int           W          = 16,
    parameter int           MAXW       = 8,
    parameter logic [W-1:0] POLY_CRC16 = 16'h8005,
    parameter logic [W-1:0] POLY_CCITT = 16'h1021,
    localparam int CW = $clog2(MAXW + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            upd,
    input  logic [1:0]      mode,
    input  logic [MAXW-1:0] chr,
    input  logic [CW-1:0]   len,
    output logic [W-1:0]    crc
);
    import rxs_pkg::*;

    logic [W-1:0] poly;
    logic         poly_on;
    logic [W-1:0] acc;
    logic         fb;

    // Choose the generator polynomial from the mode.
    always_comb begin
        poly_on = 1'b1;
        case (mode)
            CHK_CRC16: poly = POLY_CRC16;
            CHK_CCITT: poly = POLY_CCITT;
            default: begin
                poly    = '0;
                poly_on = 1'b0;
            end
        endcase
    end

    // Fold the character's active bits into the remainder.
    always_comb begin
        acc = crc;
        fb  = 1'b0;
        for (int i = 0; i < MAXW; i++) begin
            if (i < int'(len)) begin
                fb  = chr[i] ^ acc[W-1];
                acc = {acc[W-2:0], 1'b0} ^ (fb ? poly : '0);
            end
        end
    end

    // Hold the remainder; clear on hunt entry or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            crc <= '0;
        else if (upd && poly_on)
            crc <= acc;
    end

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == '0))
        else $error("block check not cleared");
endmodule

// File: rtl/rxs_receiver.sv
// Byte-synchronous receiver top. It hunts bit by bit for the SYNC
// pattern, then frames characters of LEN bits. Depending on the strip
// control it drops SYNCs or requires a SYNC pair. Data characters are
// delivered to a one-deep host register and accumulated in the block
// check. Assumes the parameter inputs are stable while rx_en is high.
module rxs_receiver #(
    parameter int MIN_W  = 5,
    parameter int MAX_W  = 8,
    parameter int CHK_W  = 16,
    localparam int CW    = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             rx_din,
    input  logic [MAX_W-1:0] sync_char,
    input  logic             strip_sync,
    input  logic [1:0]       len_code,
    input  logic [1:0]       chk_mode,
    input  logic             host_rd,
    output logic             sync_pulse,
    output logic             rx_active,
    output logic             data_avail,
    output logic [MAX_W-1:0] rx_data,
    output logic [CHK_W-1:0] chk_value
);
    import rxs_pkg::*;

    rx_state_e        st, st_n;
    logic [CW-1:0]    len_w;
    logic [MAX_W-1:0] sync_m;
    logic [MAX_W-1:0] win;
    logic             enough, boundary;
    logic             is_sync, hunt_hit, at_bnd, deliver, bad_second;

    // Character width and masked SYNC pattern.
    always_comb begin
        len_w = CW'(len_code) + CW'(MIN_W);
        for (int i = 0; i < MAX_W; i++)
            sync_m[i] = sync_char[i] & (i < int'(len_w));
    end

    rxs_deser #(.MAXW(MAX_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!rx_en),
        .align    (hunt_hit),
        .rx_din   (rx_din),
        .len      (len_w),
        .win      (win),
        .enough   (enough),
        .boundary (boundary)
    );

    // Event decode for this bit time.
    always_comb begin
        is_sync    = (win == sync_m);
        hunt_hit   = (st == ST_HUNT) && enough && is_sync;
        at_bnd     = (st != ST_HUNT) && boundary;
        deliver    = at_bnd && (st == ST_DATA) && !(strip_sync && is_sync);
        bad_second = at_bnd && (st == ST_ONE_SYNC) && !is_sync;
    end

    // Next-state: hunt -> (one SYNC) -> data.
    always_comb begin
        st_n = st;
        case (st)
            ST_HUNT:     if (hunt_hit) st_n = strip_sync ? ST_DATA : ST_ONE_SYNC;
            ST_ONE_SYNC: if (at_bnd)   st_n = is_sync ? ST_DATA : ST_HUNT;
            default:     st_n = st;
        endcase
    end

    // State, SYNC pulse and host-side holding register.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            st         <= ST_HUNT;
            sync_pulse <= 1'b0;
            rx_active  <= 1'b0;
            data_avail <= 1'b0;
            rx_data    <= '0;
        end else begin
            st         <= st_n;
            sync_pulse <= hunt_hit || (at_bnd && is_sync);
            if (deliver) begin
                rx_data    <= win;
                data_avail <= 1'b1;
                rx_active  <= 1'b1;
            end else if (host_rd) begin
                data_avail <= 1'b0;
            end
        end
    end

    rxs_bcc #(.W(CHK_W), .MAXW(MAX_W)) u_bcc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!rx_en || bad_second),
        .upd   (deliver),
        .mode  (chk_mode),
        .chr   (win),
        .len   (len_w),
        .crc   (chk_value)
    );

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse)
        else $error("sync pulse longer than one cycle");

    assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_active) |-> !$past(rx_en))
        else $error("rx_active dropped while enabled");

    assert_avail_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_avail |-> rx_active)
        else $error("data available outside a message");

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!data_avail && !rx_active && !sync_pulse))
        else $error("outputs not cleared while disabled");
endmodule

// File: tb/rxs_receiver_tb.sv
// Self-checking bench: a behavioural reference model is compared with
// every output on every clock.
module rxs_receiver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        rx_din = 1'b1;
    logic [7:0]  sync_char = 8'h16;
    logic        strip_sync = 1'b1;
    logic [1:0]  len_code = 2'd3;
    logic [1:0]  chk_mode = 2'd1;
    logic        host_rd = 1'b0;
    logic        sync_pulse, rx_active, data_avail;
    logic [7:0]  rx_data;
    logic [15:0] chk_value;

    int checks = 0;
    int fails  = 0;
    bit auto_rd = 1'b1;

    // reference model state
    bit          q[$];
    int          m_state = 0;   // 0 hunt, 1 one sync, 2 data
    int          m_cnt = 0;
    bit          m_pulse = 0, m_active = 0, m_avail = 0;
    int          m_data = 0;
    int          m_crc = 0;
    int          m_delivered = 0;

    always #10 clk = ~clk;

    rxs_receiver u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_din(rx_din),
        .sync_char(sync_char), .strip_sync(strip_sync), .len_code(len_code),
        .chk_mode(chk_mode), .host_rd(host_rd), .sync_pulse(sync_pulse),
        .rx_active(rx_active), .data_avail(data_avail), .rx_data(rx_data),
        .chk_value(chk_value)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void crc_fold(input int ch, input int len);
        int poly;
        if (chk_mode == 2'd1)      poly = 'h8005;
        else if (chk_mode == 2'd2) poly = 'h1021;
        else return;
        for (int i = 0; i < len; i++) begin
            int fb;
            fb = ((ch >> i) & 1) ^ ((m_crc >> 15) & 1);
            m_crc = (m_crc << 1) & 'hFFFF;
            if (fb != 0) m_crc = m_crc ^ poly;
        end
    endfunction

    function automatic void model_step();
        int len, smask, val, sm;
        bit hit;
        if (!rst_n || !rx_en) begin
            q.delete();
            m_state = 0; m_cnt = 0; m_pulse = 0; m_active = 0;
            m_avail = 0; m_data = 0; m_crc = 0;
            return;
        end
        q.push_back(rx_din);
        if (q.size() > 8) void'(q.pop_front());
        len = int'(len_code) + 5;
        smask = (1 << len) - 1;
        sm = int'(sync_char) & smask;
        val = 0;
        if (q.size() >= len)
            for (int i = 0; i < len; i++)
                val = val | (int'(q[q.size() - len + i]) << i);
        hit = 0;
        if (host_rd) m_avail = 0;
        if (m_state == 0) begin
            if (q.size() >= len && val == sm) begin
                hit = 1;
                m_state = strip_sync ? 2 : 1;
                m_cnt = 0;
            end
        end else begin
            m_cnt++;
            if (m_cnt == len) begin
                m_cnt = 0;
                if (val == sm) hit = 1;
                if (m_state == 1) begin
                    if (val == sm) m_state = 2;
                    else begin m_state = 0; m_crc = 0; end
                end else if (!(strip_sync && val == sm)) begin
                    m_data = val; m_avail = 1; m_active = 1;
                    m_delivered++;
                    crc_fold(val, len);
                end
            end
        end
        m_pulse = hit;
    endfunction

    task automatic compare();
        check("R6 sync_pulse", int'(sync_pulse), int'(m_pulse));
        check("R8 rx_active", int'(rx_active), int'(m_active));
        check("R7 data_avail", int'(data_avail), int'(m_avail));
        check("R2 rx_data", int'(rx_data), m_data);
        check("R10 chk_value", int'(chk_value), m_crc);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic send_bit(input bit b);
        rx_din  = b;
        host_rd = auto_rd ? data_avail : 1'b0;
        tick();
    endtask

    task automatic send_char(input int v);
        int len;
        len = int'(len_code) + 5;
        for (int i = 0; i < len; i++) send_bit(((v >> i) & 1) != 0);
    endtask

    task automatic disable_rx(input int n);
        rx_en = 1'b0;
        for (int i = 0; i < n; i++) send_bit(1'b1);
        rx_en = 1'b1;
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        // R11: reset state
        check("R11 reset outputs", int'({sync_pulse, rx_active, data_avail}), 0);
        check("R11 reset data/check", int'(rx_data) | int'(chk_value), 0);
        rst_n = 1'b1;
        rx_en = 1'b1;

        // A: 8-bit, strip on, CRC-16; R1 hunt through noise, R4 SYNC dropping
        foreach (q[i]) ;
        send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
        send_char('h16); send_char('h16);
        send_char('hA5); send_char('h3C);
        send_char('h16);                       // R3 boundary SYNC, discarded (R4)
        send_char('hFF); send_char('h00);
        check("R8 active held", int'(rx_active), 1);
        disable_rx(2);                         // R9 clear on disable
        check("R9 active cleared", int'(rx_active), 0);

        // B: strip off, CCITT; R5 SYNC pair, SYNC value delivered; no host reads
        strip_sync = 1'b0; chk_mode = 2'd2; sync_char = 8'h32;
        disable_rx(1);
        auto_rd = 1'b0;
        send_bit(0); send_bit(1);
        send_char('h32); send_char('h32);
        send_char('h32); send_char('h81); send_char('h7E);
        auto_rd = 1'b1;
        send_bit(1); send_bit(1);

        // C: R5 non-SYNC after first SYNC returns to hunt
        disable_rx(1);
        send_char('h32); send_char('h55);
        send_char('h32); send_char('h32); send_char('h12);
        send_bit(1);

        // D: 5-bit characters, CRC-16, strip on (R2 width code 0)
        len_code = 2'd0; sync_char = 8'hEB; strip_sync = 1'b1; chk_mode = 2'd1;
        disable_rx(1);
        send_bit(1); send_bit(1); send_bit(1);
        send_char('h0B); send_char('h15); send_char('h0B);
        send_char('h07); send_char('h1F);

        // E: 6-bit characters, check mode 3 = none (R10)
        len_code = 2'd1; sync_char = 8'h2D; chk_mode = 2'd3;
        disable_rx(1);
        send_char('h2D); send_char('h11); send_char('h3A);
        check("R10 mode3 check zero", int'(chk_value), 0);

        // F: 7-bit characters, strip off, CRC-16
        len_code = 2'd2; sync_char = 8'h4E; strip_sync = 1'b0; chk_mode = 2'd1;
        disable_rx(1);
        send_char('h4E); send_char('h4E); send_char('h01); send_char('h7F);
        disable_rx(2);

        check("R7 deliveries seen", int'(m_delivered > 10), 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule